// File: doc/BRIEF.md
# Encoder Write Gate with Row-Overhead Freeze

This block decides, cycle by cycle, whether an encoded pixel may be pushed into the encoder's output shift buffer. It keeps a local pixel position counter. At the start of each frame the counter is loaded with the negated pipeline latency, so it stays negative until the first real pixel reaches the encoder. After that it advances once per pixel clock. While the sensor is in its row overhead interval, no pixel data arrives, and the counter holds its value.

From the arming state, the row overhead input and the frame start strobe, the block derives a combinational "updated" flag. That flag enables the quantizer and the variable-length encoder in the same cycle. It also forms part of the buffer write enable. The write enable is further limited to a non-negative count and to every other group of four pixels. The gating is combinational, so a row overhead interval takes effect in the very cycle it starts. This holds for any programmed latency. A registered flag would lag by one clock and lose a pixel whenever the overhead begins just before a write group.

Top module: `enc_wr_gate`

## Requirements
- R1: While reset is asserted, and afterwards until the first frame start, `px_cnt` is 0 and `upd`, `quant_en`, `enc_en` and `buf_wr_en` are all 0, whatever `row_ovh` does.
- R2: A cycle with `frame_start` high arms the block. At the next clock it loads `px_cnt` with the two's complement negation of `lat_off`, modulo 2^CW.
- R3: In an armed cycle with `row_ovh` high and `frame_start` low, `px_cnt` holds its value at the next clock.
- R4: In an armed cycle with both `row_ovh` and `frame_start` low, `px_cnt` increments by one at the next clock. Before the first frame start it does not change.
- R5: `upd` is high in exactly the cycles that are armed and have both `row_ovh` and `frame_start` low. It follows those inputs combinationally, in the same cycle.
- R6: `quant_en` and `enc_en` equal `upd` in every cycle.
- R7: `buf_wr_en` is high exactly when `upd` is high, `px_cnt` is non-negative as a signed value (bit CW-1 is 0), and bit 2 of `px_cnt` equals the write-group select (default 1). Groups of four counts therefore alternate between writing and idle.
- R8: `lane` equals bits 1:0 of `px_cnt`. Within a write group, the four writes carry lanes 0, 1, 2, 3 in order.
- R9: For any latency offset and any pattern of row overhead intervals, the values of `px_cnt` at the cycles where `buf_wr_en` is high are exactly these: every count k in the range of counts the frame has visited with k ≥ 0 and bit 2 of k equal to 1, each once, in ascending order. No pixel is dropped or repeated at a row boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe that arms the block and reloads the counter |
| row_ovh | input | 1 | High while the sensor is in row overhead and sends no pixels |
| lat_off | input | CW (16) | Pipeline latency in pixels, from a software register; the counter starts at its negation |
| upd | output | 1 | Combinational counter-updated flag |
| quant_en | output | 1 | Quantizer stage enable |
| enc_en | output | 1 | Variable-length encoder stage enable |
| buf_wr_en | output | 1 | Output shift buffer write enable |
| px_cnt | output | CW (16) | Local encoder pixel counter, two's complement |
| lane | output | 2 | Position of the current pixel inside its group of four |

## Verification
Every cycle, the assertions check the counter's load, hold and step rules (R2 to R4), the same-cycle link between the row overhead input and `upd` (R5), and the enable and write qualification (R6, R7). They cannot show that the stream of written counts is complete across rows. That is a property of whole frames: it depends on where the overhead intervals fall relative to the four-count write groups. The scoreboard therefore sweeps the latency offset under two row and overhead shapes. Some overhead starts land one cycle before a write group, and the scoreboard confirms each expected count is written exactly once (R8, R9).

// File: rtl/ewg_pkg.sv
package ewg_pkg;

    // Operation the control logic requests from the counter each cycle.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,  // not armed yet: keep value
        OP_LOAD = 2'd1,  // frame start: load negated latency
        OP_STEP = 2'd2,  // pixel present: advance
        OP_HOLD = 2'd3   // row overhead: freeze
    } cnt_op_e;

endpackage

// File: rtl/ewg_ctrl.sv
module ewg_ctrl
    import ewg_pkg::*;
(
    input  logic    armed,
    input  logic    frame_start,
    input  logic    row_ovh,
    output cnt_op_e op,
    output logic    upd
);

    // Purely combinational so the gate tracks row overhead in the same cycle.
    always_comb begin
        upd = armed & ~row_ovh & ~frame_start;
        if (frame_start) begin
            op = OP_LOAD;
        end else if (!armed) begin
            op = OP_IDLE;
        end else if (row_ovh) begin
            op = OP_HOLD;
        end else begin
            op = OP_STEP;
        end
    end

endmodule

// File: rtl/ewg_counter.sv
module ewg_counter
    import ewg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_op_e       op,
    input  logic [CW-1:0] lat_off,
    output logic [CW-1:0] cnt,
    output logic          armed
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD: begin
                st_d.armed = 1'b1;
                st_d.cnt   = '0 - lat_off;
            end
            OP_STEP: st_d.cnt = st_q.cnt + ONE;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt   = st_q.cnt;
    assign armed = st_q.armed;

endmodule

// File: rtl/ewg_wgate.sv
module ewg_wgate #(
    parameter int CW       = 16,
    parameter int GRP_LOG2 = 2,
    parameter bit WR_GRP   = 1'b1
) (
    input  logic                upd,
    input  logic [CW-1:0]       cnt,
    output logic                quant_en,
    output logic                enc_en,
    output logic                buf_wr_en,
    output logic [GRP_LOG2-1:0] lane
);

    logic nonneg;
    logic wr_phase;

    always_comb begin
        nonneg    = ~cnt[CW-1];
        wr_phase  = (cnt[GRP_LOG2] == WR_GRP);
        quant_en  = upd;
        enc_en    = upd;
        buf_wr_en = upd & nonneg & wr_phase;
        lane      = cnt[GRP_LOG2-1:0];
    end

endmodule

// File: rtl/enc_wr_gate.sv
module enc_wr_gate
    import ewg_pkg::*;
#(
    parameter int CW       = 16,
    parameter int GRP_LOG2 = 2,
    parameter bit WR_GRP   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                row_ovh,
    input  logic [CW-1:0]       lat_off,
    output logic                upd,
    output logic                quant_en,
    output logic                enc_en,
    output logic                buf_wr_en,
    output logic [CW-1:0]       px_cnt,
    output logic [GRP_LOG2-1:0] lane
);

    cnt_op_e op_w;
    logic    armed_w;
    logic    upd_w;

    ewg_ctrl u_ctrl (
        .armed       (armed_w),
        .frame_start (frame_start),
        .row_ovh     (row_ovh),
        .op          (op_w),
        .upd         (upd_w)
    );

    ewg_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op_w),
        .lat_off (lat_off),
        .cnt     (px_cnt),
        .armed   (armed_w)
    );

    ewg_wgate #(.CW(CW), .GRP_LOG2(GRP_LOG2), .WR_GRP(WR_GRP)) u_gate (
        .upd       (upd_w),
        .cnt       (px_cnt),
        .quant_en  (quant_en),
        .enc_en    (enc_en),
        .buf_wr_en (buf_wr_en),
        .lane      (lane)
    );

    assign upd = upd_w;

endmodule

// File: rtl/enc_wr_gate_chk.sv
module enc_wr_gate_chk #(
    parameter int CW       = 16,
    parameter int GRP_LOG2 = 2,
    parameter bit WR_GRP   = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          row_ovh,
    input logic [CW-1:0] lat_off,
    input logic          armed,
    input logic          upd,
    input logic          quant_en,
    input logic          enc_en,
    input logic          buf_wr_en,
    input logic [CW-1:0] px_cnt
);

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] neg_off;
    assign neg_off = '0 - lat_off;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (px_cnt == $past(neg_off)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && row_ovh && !frame_start) |=> $stable(px_cnt));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !row_ovh && !frame_start) |=> (px_cnt == $past(px_cnt) + ONE));

    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !frame_start) |=> $stable(px_cnt));

    p_upd_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (row_ovh || frame_start || !armed) |-> !upd);

    p_upd_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !row_ovh && !frame_start) |-> upd);

    p_enables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (quant_en == upd) && (enc_en == upd));

    p_write_qual_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (upd && !px_cnt[CW-1] && (px_cnt[GRP_LOG2] == WR_GRP)));

endmodule

bind enc_wr_gate enc_wr_gate_chk #(.CW(CW), .GRP_LOG2(GRP_LOG2), .WR_GRP(WR_GRP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .row_ovh     (row_ovh),
    .lat_off     (lat_off),
    .armed       (armed_w),
    .upd         (upd),
    .quant_en    (quant_en),
    .enc_en      (enc_en),
    .buf_wr_en   (buf_wr_en),
    .px_cnt      (px_cnt)
);

// File: tb/enc_wr_gate_test.sv
module enc_wr_gate_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          row_ovh = 1'b1;
    logic [CW-1:0] lat_off = '0;
    logic          upd, quant_en, enc_en, buf_wr_en;
    logic [CW-1:0] px_cnt;
    logic [1:0]    lane;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int exp_q[$];

    always #5 clk = ~clk;

    enc_wr_gate uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_ovh(row_ovh),
        .lat_off(lat_off), .upd(upd), .quant_en(quant_en), .enc_en(enc_en),
        .buf_wr_en(buf_wr_en), .px_cnt(px_cnt), .lane(lane)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: samples 1 ns before each rising edge.
    bit            armed_m = 1'b0;
    bit            prev_v = 1'b0;
    bit            prev_fs, prev_ovh, prev_arm;
    logic [CW-1:0] prev_cnt, prev_neg;

    always @(negedge clk) begin
        #4;
        if (!rst_n) begin
            prev_v = 1'b0;
            armed_m = 1'b0;
        end else begin
            bit exp_upd;
            bit exp_wr;
            if (prev_v) begin
                if (prev_fs)
                    chk(px_cnt == prev_neg, "R2 load", px_cnt, prev_neg);
                else if (prev_arm && !prev_ovh)
                    chk(px_cnt == prev_cnt + 16'd1, "R4 step", px_cnt, prev_cnt + 16'd1);
                else if (prev_arm)
                    chk(px_cnt == prev_cnt, "R3 hold", px_cnt, prev_cnt);
                else
                    chk(px_cnt == prev_cnt, "R4 idle", px_cnt, prev_cnt);
            end
            exp_upd = armed_m && !row_ovh && !frame_start;
            chk(upd == exp_upd, "R5 upd", upd, exp_upd);
            chk(quant_en == exp_upd && enc_en == exp_upd, "R6 enables",
                {quant_en, enc_en}, {exp_upd, exp_upd});
            exp_wr = exp_upd && !px_cnt[CW-1] && px_cnt[2];
            chk(buf_wr_en == exp_wr, "R7 write enable", buf_wr_en, exp_wr);
            if (buf_wr_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected write", $signed(px_cnt), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk($signed(px_cnt) == e, "R9 written count", $signed(px_cnt), e);
                    chk(lane == e[1:0], "R8 lane", lane, e[1:0]);
                end
            end
            prev_v   = 1'b1;
            prev_fs  = frame_start;
            prev_ovh = row_ovh;
            prev_arm = armed_m;
            prev_cnt = px_cnt;
            prev_neg = 16'd0 - lat_off;
            if (frame_start) armed_m = 1'b1;
        end
    end

    // Driver: one frame of rows, each row followed by an overhead interval.
    task automatic run_frame(input int off, input int rows, input int rw, input int ov);
        int first;
        int last;
        first = -off;
        last  = -off + rows * rw - 1;
        for (int k = first; k <= last; k++)
            if (k >= 0 && k[2]) exp_q.push_back(k);
        @(negedge clk);
        lat_off     = off[CW-1:0];
        frame_start = 1'b1;
        row_ovh     = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < rw; c++) begin
                row_ovh = 1'b0;
                @(negedge clk);
            end
            for (int c = 0; c < ov; c++) begin
                row_ovh = 1'b1;
                @(negedge clk);
            end
        end
        row_ovh = 1'b1;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all pixels written", exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #4;
        // R1: reset state
        chk(px_cnt == 0 && !upd && !buf_wr_en && !quant_en && !enc_en,
            "R1 reset outputs", {upd, buf_wr_en, px_cnt}, 0);
        @(negedge clk);
        rst_n   = 1'b1;
        row_ovh = 1'b0;
        repeat (5) @(negedge clk);
        #4;
        // R1: unarmed, no overhead, still silent
        chk(px_cnt == 0 && !upd && !buf_wr_en, "R1 unarmed outputs",
            {upd, buf_wr_en, px_cnt}, 0);
        @(negedge clk);
        // R2: direct check of the load value
        lat_off     = 16'd5;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        row_ovh     = 1'b1;
        #4;
        chk($signed(px_cnt) == -5, "R2 load of -5", $signed(px_cnt), -5);
        // R5: upd reacts in the same cycle to row_ovh
        @(negedge clk);
        row_ovh = 1'b0;
        #1;
        chk(upd == 1'b1, "R5 same-cycle rise", upd, 1);
        row_ovh = 1'b1;
        #1;
        chk(upd == 1'b0, "R5 same-cycle fall", upd, 0);
        // R9: latency sweep under two row shapes
        for (int off = 0; off < 12; off++) run_frame(off, 6, 11, 3);
        for (int off = 0; off < 12; off++) run_frame(off, 5, 13, 1);
        run_frame(40, 4, 20, 2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule